// File: doc/BRIEF.md
# Minicomputer Carry, Shift and Skip Unit

This block finishes an emulated minicomputer arithmetic instruction after the ALU has run. The ALU result and carry-out come in, along with the current instruction word. The block builds the carry that enters the shifter from two things: a preset-or-complement control applied to the stored CARRY, and an inversion that applies only when the ALU function is one that produces a carry. It then shifts the 17-bit value made of that carry and the result. The shifter output feeds three things: a skip test, a write-back decision, and the stored CARRY and SKIP flip-flops.

Each cycle of a `dns_strobe` is one arithmetic instruction. The shifted result and the register-write enable are combinational outputs in that cycle. CARRY and SKIP change at the clock edge that ends the cycle. A separate `ir_load` strobe marks a new instruction being fetched, and it clears SKIP. All pins are plain control and data pins and have no handshake. The unit takes no back-pressure, because a microcode cycle always completes.

Top module: `carry_skip_unit`

## Requirements
- R1: The carry-control field, instruction bits 5:4, sets the base carry. Code 0 keeps the stored CARRY, code 1 gives 0, code 2 gives 1 and code 3 gives the complement of CARRY.
- R2: The ALU-function field, instruction bits 10:8, decides whether the ALU carry-out matters. For codes 1, 3, 4, 5 and 6, an ALU carry-out of 1 inverts the base carry. Codes 0, 2 and 7 pass the base carry unchanged.
- R3: The shift field, instruction bits 7:6, shifts the 17-bit value {carry, result}. Code 0 passes it through, code 1 rotates it left by one, code 2 rotates it right by one and code 3 swaps the two result bytes. The shifted result appears on `shift_out` in the same cycle.
- R4: The carry that leaves the shifter is defined per shift code. A left rotate gives the old result MSB, a right rotate gives the old result LSB, and a byte swap or no shift keeps the incoming carry.
- R5: `reg_we` is 1 exactly when `dns_strobe` is 1 and the no-load bit, instruction bit 3, is 0.
- R6: At a `dns_strobe` edge with the no-load bit 0, CARRY takes the shifter carry. In every other cycle CARRY keeps its value.
- R7: At a `dns_strobe` edge, SKIP is set from the skip field, instruction bits 2:0, using the shifter output and shifter carry. The codes are:
  - 0: clear.
  - 1: set.
  - 2: carry is 0.
  - 3: carry is 1.
  - 4: result is zero.
  - 5: result is nonzero.
  - 6: result is zero or carry is 0.
  - 7: result is nonzero and carry is 1.
- R8: At an edge where `ir_load` is 1, SKIP becomes 0, including when `dns_strobe` is also 1.
- R9: Reset clears SKIP and CARRY to 0. SKIP keeps its value in any cycle that has neither strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_in | input | 16 | Current instruction word |
| alu_res | input | DW | ALU result |
| alu_cout | input | 1 | ALU carry-out |
| dns_strobe | input | 1 | Arithmetic completion function this cycle |
| ir_load | input | 1 | Instruction load this cycle (clears SKIP) |
| shift_out | output | DW | Shifted result for write-back |
| reg_we | output | 1 | Destination register write enable |
| skip_o | output | 1 | SKIP flip-flop |
| carry_o | output | 1 | CARRY flip-flop |

## Verification
An exhaustive sweep covers every combination of carry control, ALU function, shift, no-load and skip code, and it runs twice: once with ALU carry-out at 0 and once at 1. If a design inverted the carry for the logical functions, or ignored the complement code, CARRY would drift from the model on the next test. Results of 0, 0x8000 and 0x0001 are injected so that rotates produce a zero result. A design that tested the zero condition before the shift instead of after it would then report the wrong skip. Some cycles set the no-load bit, and some cycles assert `ir_load` alongside `dns_strobe`. Those cycles expose a design that updates CARRY without write-back, or that lets the skip test win over the instruction-load clear.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int IR_W = 16;

  localparam int SKIP_LO  = 0;
  localparam int NOLD_BIT = 3;
  localparam int CCTL_LO  = 4;
  localparam int SHF_LO   = 6;
  localparam int FUNC_LO  = 8;

  typedef enum logic [1:0] {
    CC_KEEP = 2'd0,
    CC_ZERO = 2'd1,
    CC_ONE  = 2'd2,
    CC_COMP = 2'd3
  } cctl_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_ROL  = 2'd1,
    SH_ROR  = 2'd2,
    SH_SWAP = 2'd3
  } shf_e;

  typedef enum logic [2:0] {
    SK_NEVER = 3'd0,
    SK_ALW   = 3'd1,
    SK_CZ    = 3'd2,
    SK_CNZ   = 3'd3,
    SK_RZ    = 3'd4,
    SK_RNZ   = 3'd5,
    SK_EITH  = 3'd6,
    SK_BOTH  = 3'd7
  } skc_e;

  typedef struct packed {
    logic [2:0] func;
    shf_e       shf;
    cctl_e      cctl;
    logic       noload;
    skc_e       skc;
  } ir_fields_t;

  function automatic ir_fields_t split_ir(input logic [IR_W-1:0] w);
    ir_fields_t f;
    f.func   = w[FUNC_LO +: 3];
    f.shf    = shf_e'(w[SHF_LO +: 2]);
    f.cctl   = cctl_e'(w[CCTL_LO +: 2]);
    f.noload = w[NOLD_BIT];
    f.skc    = skc_e'(w[SKIP_LO +: 3]);
    return f;
  endfunction

  // Arithmetic functions whose carry-out may flip the carry.
  function automatic logic func_uses_cout(input logic [2:0] fn);
    case (fn)
      3'd0, 3'd2, 3'd7: return 1'b0;
      default:          return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/csu_carry_gen.sv
module csu_carry_gen
  import csu_pkg::*;
(
  input  cctl_e      cctl,
  input  logic [2:0] func,
  input  logic       stored_c,
  input  logic       alu_cout,
  output logic       pre_c
);
  logic base_c;

  always_comb begin
    unique case (cctl)
      CC_KEEP: base_c = stored_c;
      CC_ZERO: base_c = 1'b0;
      CC_ONE:  base_c = 1'b1;
      CC_COMP: base_c = ~stored_c;
      default: base_c = stored_c;
    endcase
  end

  assign pre_c = base_c ^ (alu_cout & func_uses_cout(func));
endmodule

// File: rtl/csu_shifter.sv
module csu_shifter
  import csu_pkg::*;
#(
  parameter int DW = 16
) (
  input  shf_e          mode,
  input  logic          c_in,
  input  logic [DW-1:0] d_in,
  output logic          c_out,
  output logic [DW-1:0] d_out
);
  localparam int HALF = DW / 2;

  logic [DW-1:0] swapped;

  generate
    if ((DW % 2) == 0) begin : g_even
      assign swapped = {d_in[HALF-1:0], d_in[DW-1:HALF]};
    end else begin : g_odd
      assign swapped = d_in;
    end
  endgenerate

  always_comb begin
    c_out = c_in;
    d_out = d_in;
    unique case (mode)
      SH_NONE: ;
      SH_ROL:  {c_out, d_out} = {d_in, c_in};
      SH_ROR:  {d_out, c_out} = {c_in, d_in};
      SH_SWAP: d_out = swapped;
      default: ;
    endcase
  end
endmodule

// File: rtl/csu_skip_eval.sv
module csu_skip_eval
  import csu_pkg::*;
#(
  parameter int DW = 16
) (
  input  skc_e          cond,
  input  logic          c,
  input  logic [DW-1:0] r,
  output logic          take
);
  logic rz;
  assign rz = (r == '0);

  always_comb begin
    unique case (cond)
      SK_NEVER: take = 1'b0;
      SK_ALW:   take = 1'b1;
      SK_CZ:    take = ~c;
      SK_CNZ:   take = c;
      SK_RZ:    take = rz;
      SK_RNZ:   take = ~rz;
      SK_EITH:  take = rz | ~c;
      SK_BOTH:  take = ~rz & c;
      default:  take = 1'b0;
    endcase
  end
endmodule

// File: rtl/carry_skip_unit.sv
module carry_skip_unit
  import csu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IR_W-1:0] ir_in,
  input  logic [DW-1:0]   alu_res,
  input  logic            alu_cout,
  input  logic            dns_strobe,
  input  logic            ir_load,
  output logic [DW-1:0]   shift_out,
  output logic            reg_we,
  output logic            skip_o,
  output logic            carry_o
);
  ir_fields_t f;
  logic       pre_c;
  logic       post_c;
  logic       skip_take;
  logic       carry_q;
  logic       skip_q;

  assign f = split_ir(ir_in);

  csu_carry_gen u_cgen (
    .cctl     (f.cctl),
    .func     (f.func),
    .stored_c (carry_q),
    .alu_cout (alu_cout),
    .pre_c    (pre_c)
  );

  csu_shifter #(.DW(DW)) u_shf (
    .mode  (f.shf),
    .c_in  (pre_c),
    .d_in  (alu_res),
    .c_out (post_c),
    .d_out (shift_out)
  );

  csu_skip_eval #(.DW(DW)) u_skip (
    .cond (f.skc),
    .c    (post_c),
    .r    (shift_out),
    .take (skip_take)
  );

  assign reg_we = dns_strobe & ~f.noload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      if (reg_we) carry_q <= post_c;
      if (ir_load)         skip_q <= 1'b0;
      else if (dns_strobe) skip_q <= skip_take;
    end
  end

  assign skip_o  = skip_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/csu_checker.sv
module csu_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   ir_in,
  input logic [DW-1:0] alu_res,
  input logic          dns_strobe,
  input logic          ir_load,
  input logic [DW-1:0] shift_out,
  input logic          reg_we,
  input logic          skip_o,
  input logic          carry_o
);
  assert_we_needs_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dns_strobe |-> !reg_we);

  assert_we_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ir_in[3] |-> !reg_we);

  assert_carry_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(carry_o));

  assert_irload_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> !skip_o);

  assert_skip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dns_strobe && !ir_load) |=> $stable(skip_o));

  assert_skip_always_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dns_strobe && !ir_load && ir_in[2:0] == 3'd1) |=> skip_o);

  assert_skip_never_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dns_strobe && ir_in[2:0] == 3'd0) |=> !skip_o);

  assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_in[7:6] == 2'd0) |-> (shift_out == alu_res));
endmodule

bind carry_skip_unit csu_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ir_in      (ir_in),
  .alu_res    (alu_res),
  .dns_strobe (dns_strobe),
  .ir_load    (ir_load),
  .shift_out  (shift_out),
  .reg_we     (reg_we),
  .skip_o     (skip_o),
  .carry_o    (carry_o)
);

// File: tb/sim_carry_skip_unit.sv
module sim_carry_skip_unit;
  localparam int CLK_P = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   ir_in = '0;
  logic [DW-1:0] alu_res = '0;
  logic          alu_cout = 1'b0;
  logic          dns_strobe = 1'b0;
  logic          ir_load = 1'b0;
  logic [DW-1:0] shift_out;
  logic          reg_we;
  logic          skip_o;
  logic          carry_o;

  int n_chk = 0;
  int n_bad = 0;
  logic m_carry = 1'b0;
  logic m_skip = 1'b0;
  int unsigned seed_v;

  always #(CLK_P/2) clk = ~clk;

  carry_skip_unit #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .alu_res(alu_res),
    .alu_cout(alu_cout), .dns_strobe(dns_strobe), .ir_load(ir_load),
    .shift_out(shift_out), .reg_we(reg_we), .skip_o(skip_o), .carry_o(carry_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: carry into shifter (R1, R2).
  function automatic logic ref_pre(input logic [15:0] w, input logic sc, input logic co);
    logic b;
    case (w[5:4])
      2'd0: b = sc;
      2'd1: b = 1'b0;
      2'd2: b = 1'b1;
      default: b = ~sc;
    endcase
    if (co && !(w[10:8] == 3'd0 || w[10:8] == 3'd2 || w[10:8] == 3'd7)) b = ~b;
    return b;
  endfunction

  // Reference: shifter (R3, R4); returns {carry, result}.
  function automatic logic [DW:0] ref_shift(input logic [1:0] m, input logic c, input logic [DW-1:0] r);
    case (m)
      2'd1: return {r[DW-1], r[DW-2:0], c};
      2'd2: return {r[0], c, r[DW-1:1]};
      2'd3: return {c, r[7:0], r[15:8]};
      default: return {c, r};
    endcase
  endfunction

  function automatic logic ref_skip(input logic [2:0] k, input logic c, input logic [DW-1:0] r);
    logic z;
    z = (r == '0);
    case (k)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return ~c;
      3'd3: return c;
      3'd4: return z;
      3'd5: return ~z;
      3'd6: return z | ~c;
      default: return ~z & c;
    endcase
  endfunction

  task automatic step(input logic [15:0] w, input logic [DW-1:0] r, input logic co,
                      input logic dns, input logic irl);
    logic [DW:0] sh;
    logic pc, sk;
    @(negedge clk);
    ir_in = w; alu_res = r; alu_cout = co; dns_strobe = dns; ir_load = irl;
    #(CLK_P/4);
    pc = ref_pre(w, m_carry, co);
    sh = ref_shift(w[7:6], pc, r);
    sk = ref_skip(w[2:0], sh[DW], sh[DW-1:0]);
    chk("R3 shift_out", 32'(shift_out), 32'(sh[DW-1:0]));
    chk("R5 reg_we", 32'(reg_we), 32'(dns & ~w[3]));
    if (dns && !w[3]) m_carry = sh[DW];
    if (irl) m_skip = 1'b0;
    else if (dns) m_skip = sk;
    @(posedge clk);
    #1;
    chk("R1 R2 R4 R6 carry_o", 32'(carry_o), 32'(m_carry));
    chk("R7 R8 R9 skip_o", 32'(skip_o), 32'(m_skip));
  endtask

  function automatic logic [DW-1:0] pick_res();
    case ($urandom % 6)
      0: return '0;
      1: return 16'h8000;
      2: return 16'h0001;
      default: return DW'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset skip", 32'(skip_o), 32'd0);
    chk("R9 reset carry", 32'(carry_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: force carry 1 via code 2, pass, write-back, skip on carry=1.
    step(16'h0023, 16'h1234, 1'b0, 1'b1, 1'b0);
    chk("R1 preset one", 32'(carry_o), 32'd1);
    chk("R7 skip carry set", 32'(skip_o), 32'd1);
    // Idle: both flops hold (R9, R6).
    step(16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0);
    chk("R9 idle hold skip", 32'(skip_o), 32'd1);
    // No-load: carry forced 0 but not stored.
    step(16'h0018, 16'h0000, 1'b0, 1'b1, 1'b0);
    chk("R6 noload keeps carry", 32'(carry_o), 32'd1);
    // IR load together with an always-skip.
    step(16'h0001, 16'h0000, 1'b0, 1'b1, 1'b1);
    chk("R8 irload wins", 32'(skip_o), 32'd0);
    // Rotate left of 0x8000 with carry 0 -> result 0, carry 1, SZR skips.
    step(16'h0054, 16'h8000, 1'b0, 1'b1, 1'b0);
    chk("R4 rol carry", 32'(carry_o), 32'd1);
    chk("R7 post-shift zero", 32'(skip_o), 32'd1);
    // ADD with carry-out inverts preset 0.
    step(16'h0613, 16'h0001, 1'b1, 1'b1, 1'b0);
    chk("R2 invert", 32'(carry_o), 32'd1);

    // Exhaustive sweep of all field codes, both ALU carry-out values.
    for (int co = 0; co < 2; co++)
      for (int w = 0; w < 2048; w++)
        step({5'(($urandom % 32) & 5'h10), w[10:0]}, pick_res(), co[0], 1'b1, 1'b0);

    // Random mix including idle and ir_load cycles.
    for (int i = 0; i < 2500; i++) begin
      int sel;
      sel = $urandom % 10;
      step(16'($urandom), pick_res(), 1'($urandom), sel != 0, sel == 1 || sel == 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule